// File: doc/BRIEF.md
# 3x3 Matrix Multiply Color Converter

This block multiplies a three-element vector of signed integer samples by a programmable 3x3 matrix of signed fractional coefficients, once per accepted beat. Typical use is color-space conversion between component formats, for example from red/green/blue to luma/color-difference and back. Each of the three outputs is one matrix row applied to the same three inputs. The full sum is cut back to the integer width of the inputs, so results can feed another stage of the same format.

Samples enter and results leave through valid/ready streams. A beat is accepted on a rising edge when `in_valid` and `in_ready` are both high. A result is delivered on a rising edge when `out_valid` and `out_ready` are both high. The pipeline moves as one unit. It holds whenever a result is waiting and the consumer is not ready. `in_ready` is high exactly when the output stage is empty or is being drained, so it depends on `out_ready` within the same cycle. While the consumer keeps `out_ready` high, one beat is accepted per clock.

Coefficients are written one row at a time through three coefficient ports and a 2-bit row-select code. These writes do not depend on the stream handshake.

Top module: `mm3_color_matrix`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, all three outputs read 0 and every coefficient is 0, so later beats produce 0 until coefficients are written.
- R2: Coefficients are 10-bit two's complement with nine fraction bits: bit 9 weighs -1 and bit 0 weighs 1/512, covering -1.0 to +511/512. Data words are 12-bit two's complement integers.
- R3: On a rising edge, `coef_we` selects the row to write. 2'b00 writes nothing. 2'b01 writes the row that drives `out_x`, 2'b10 the row for `out_y`, and 2'b11 the row for `out_z`. Within the selected row, `coef_a`, `coef_b` and `coef_c` become the weights of `in_a`, `in_b` and `in_c`. The other rows keep their values.
- R4: Each output equals the sum of the three inputs, each multiplied by that output row's coefficient for the input.
- R5: Each output is the full-precision sum shifted right arithmetically by nine bits (rounding toward minus infinity), keeping its low 12 bits. There is no rounding and no saturation, so out-of-range sums wrap.
- R6: With `out_ready` held high, a beat accepted on rising edge k appears on the outputs, with `out_valid` high, right after edge k+5. One result can leave every clock.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the outputs and `out_valid` hold their values into the next cycle.
- R8: Without back-pressure, a row write on edge k applies to the beat accepted on edge k and to every later beat. It does not apply to beats accepted before edge k.
- R9: Results leave in acceptance order, one per accepted beat. `out_valid` is never raised for a cycle in which `in_valid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_a | input | 12 | First input component |
| in_b | input | 12 | Second input component |
| in_c | input | 12 | Third input component |
| coef_we | input | 2 | Row-select code for coefficient write |
| coef_a | input | 10 | Coefficient for `in_a` in the selected row |
| coef_b | input | 10 | Coefficient for `in_b` in the selected row |
| coef_c | input | 10 | Coefficient for `in_c` in the selected row |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_x | output | 12 | Result of the first row |
| out_y | output | 12 | Result of the second row |
| out_z | output | 12 | Result of the third row |

## Verification
A corrupted coefficient register appears only on its own output. The first wrong result comes out six sampling points after the first beat that reads that register. This lets a row or column mix-up be located from which port disagrees. A stage that drops or duplicates its valid bit shows up at once as a result that is missing, extra, or off by a cycle against the fixed latency. A misplaced truncation field shows up on the first corner beat, such as full-scale data with full-scale coefficients or -1 times the smallest coefficient. A stall that leaks appears as output data that changes while the consumer holds `out_ready` low.

// File: rtl/mm3_pkg.sv
package mm3_pkg;
  localparam int NROWS = 3;
  localparam int NCOLS = 3;

  typedef enum logic [1:0] {
    WE_NONE  = 2'b00,
    WE_ROW_X = 2'b01,
    WE_ROW_Y = 2'b10,
    WE_ROW_Z = 2'b11
  } coef_we_e;

  function automatic coef_we_e row_code(int r);
    case (r)
      0:       return WE_ROW_X;
      1:       return WE_ROW_Y;
      default: return WE_ROW_Z;
    endcase
  endfunction
endpackage

// File: rtl/mm3_coef_bank.sv
module mm3_coef_bank import mm3_pkg::*; #(
  parameter int CW = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  we,
  input  logic [CW-1:0]               k_a,
  input  logic [CW-1:0]               k_b,
  input  logic [CW-1:0]               k_c,
  output logic [NROWS*NCOLS*CW-1:0]   bank_q
);
  localparam int ROWW = NCOLS * CW;

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    localparam coef_we_e CODE = row_code(r);
    logic [ROWW-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           row_q <= '0;
      else if (we == CODE)  row_q <= {k_c, k_b, k_a};
    end

    assign bank_q[r*ROWW +: ROWW] = row_q;
  end
endmodule

// File: rtl/mm3_mul.sv
module mm3_mul #(
  parameter int AW     = 12,
  parameter int BW     = 10,
  parameter int STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [AW-1:0]     a,
  input  logic signed [BW-1:0]     b,
  output logic signed [AW+BW-1:0]  p
);
  localparam int PW = AW + BW;

  logic signed [PW-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else if (en) begin
      stage_q[0] <= PW'(a) * PW'(b);
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign p = stage_q[STAGES-1];
endmodule

// File: rtl/mm3_row.sv
module mm3_row import mm3_pkg::*; #(
  parameter int DW         = 12,
  parameter int CW         = 10,
  parameter int MUL_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic signed [DW-1:0]  d_a,
  input  logic signed [DW-1:0]  d_b,
  input  logic signed [DW-1:0]  d_c,
  input  logic [NCOLS*CW-1:0]   k_row,
  output logic [DW-1:0]         res
);
  localparam int PW   = DW + CW;
  localparam int SW   = PW + 2;
  localparam int FRAC = CW - 1;

  logic signed [DW-1:0] din  [NCOLS];
  logic signed [PW-1:0] prod [NCOLS];

  assign din[0] = d_a;
  assign din[1] = d_b;
  assign din[2] = d_c;

  for (genvar c = 0; c < NCOLS; c++) begin : g_mul
    mm3_mul #(.AW(DW), .BW(CW), .STAGES(MUL_STAGES)) u_mul (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .a    (din[c]),
      .b    ($signed(k_row[c*CW +: CW])),
      .p    (prod[c])
    );
  end

  // two-level adder tree: pair sum, then add the third product
  logic signed [SW-1:0] pair_q;
  logic signed [PW-1:0] third_q;
  logic signed [SW-1:0] full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q  <= '0;
      third_q <= '0;
      full_q  <= '0;
      res     <= '0;
    end else if (en) begin
      pair_q  <= SW'(prod[0]) + SW'(prod[1]);
      third_q <= prod[2];
      full_q  <= pair_q + SW'(third_q);
      res     <= DW'(full_q >>> FRAC);
    end
  end
endmodule

// File: rtl/mm3_color_matrix.sv
module mm3_color_matrix import mm3_pkg::*; #(
  parameter int DW         = 12,
  parameter int CW         = 10,
  parameter int MUL_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_c,
  input  logic [1:0]    coef_we,
  input  logic [CW-1:0] coef_a,
  input  logic [CW-1:0] coef_b,
  input  logic [CW-1:0] coef_c,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_x,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_z
);
  // input register + multiplier stages + pair + full + output
  localparam int LAT  = MUL_STAGES + 4;
  localparam int ROWW = NCOLS * CW;

  logic             adv;
  logic [LAT-1:0]   vld_q;
  logic [DW-1:0]    a_q, b_q, c_q;
  logic [NROWS*ROWW-1:0] bank_q;
  logic [DW-1:0]    res [NROWS];

  assign out_valid = vld_q[LAT-1];
  assign adv       = !out_valid || out_ready;
  assign in_ready  = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vld_q <= '0;
    else if (adv) vld_q <= {vld_q[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (adv && in_valid) begin
      a_q <= in_a;
      b_q <= in_b;
      c_q <= in_c;
    end
  end

  mm3_coef_bank #(.CW(CW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (coef_we),
    .k_a   (coef_a),
    .k_b   (coef_b),
    .k_c   (coef_c),
    .bank_q(bank_q)
  );

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    mm3_row #(.DW(DW), .CW(CW), .MUL_STAGES(MUL_STAGES)) u_row (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (adv),
      .d_a  ($signed(a_q)),
      .d_b  ($signed(b_q)),
      .d_c  ($signed(c_q)),
      .k_row(bank_q[r*ROWW +: ROWW]),
      .res  (res[r])
    );
  end

  assign out_x = res[0];
  assign out_y = res[1];
  assign out_z = res[2];
endmodule

// File: rtl/mm3_color_matrix_chk.sv
module mm3_color_matrix_chk #(
  parameter int DW  = 12,
  parameter int CW  = 10,
  parameter int LAT = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [DW-1:0]   out_x,
  input logic [DW-1:0]   out_y,
  input logic [DW-1:0]   out_z,
  input logic [1:0]      coef_we,
  input logic [9*CW-1:0] bank_flat
);
  int occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= 0;
    else occ <= occ + ((in_valid && in_ready) ? 1 : 0)
                    - ((out_valid && out_ready) ? 1 : 0);
  end

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y) && $stable(out_z));

  // R7
  no_accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R3
  idle_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we == 2'b00 |=> $stable(bank_flat));

  // R3
  row_x_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we == 2'b01 |=> $stable(bank_flat[3*CW +: 6*CW]));

  // R6
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ >= 0 && occ <= LAT);

  // R9
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ != 0);
endmodule

bind mm3_color_matrix mm3_color_matrix_chk #(.DW(DW), .CW(CW), .LAT(LAT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_x    (out_x),
  .out_y    (out_y),
  .out_z    (out_z),
  .coef_we  (coef_we),
  .bank_flat(bank_q)
);

// File: tb/mm3_color_matrix_test.sv
module mm3_color_matrix_test;
  localparam int DW = 12;
  localparam int CW = 10;
  localparam int LATS = 6; // sampling points from accept to visible result

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, out_ready = 1'b1;
  logic          in_ready, out_valid;
  logic [DW-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic [1:0]    coef_we = '0;
  logic [CW-1:0] coef_a = '0, coef_b = '0, coef_c = '0;
  logic [DW-1:0] out_x, out_y, out_z;

  mm3_color_matrix uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .coef_we(coef_we),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_z(out_z)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, last_stall = -1;
  logic [CW-1:0] mb [3][3];
  logic [3*DW-1:0] exp_q [$];
  int              acc_q [$];
  string           req_q [$];
  logic [3*DW-1:0] prev_out;
  bit              prev_stall = 1'b0;
  string           cur_req;

  int dvals [7] = '{-2048, -2047, -1, 0, 1, 1000, 2047};
  int cvals [7] = '{-512, -256, -1, 0, 1, 255, 511};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R4 R5: sum of integer*fraction, floor by 2^9, low 12 bits
  function automatic logic [DW-1:0] ref_dot(int r, logic [DW-1:0] a, logic [DW-1:0] b,
                                            logic [DW-1:0] c);
    int s;
    s = int'($signed(a)) * int'($signed(mb[r][0]))
      + int'($signed(b)) * int'($signed(mb[r][1]))
      + int'($signed(c)) * int'($signed(mb[r][2]));
    return DW'(s >>> (CW - 1));
  endfunction

  task automatic step(input bit iv, input int a, input int b, input int c,
                      input logic [1:0] we, input int ka, input int kb, input int kc,
                      input bit ordy);
    @(negedge clk);
    cyc++;
    if (out_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R9", "valid with nothing accepted", 1, 0);
      else begin
        check({out_x, out_y, out_z} == exp_q[0], req_q[0], "result",
              {out_x, out_y, out_z}, exp_q[0]);
        if (acc_q[0] > last_stall)
          check(cyc - acc_q[0] == LATS, "R6", "latency", cyc - acc_q[0], LATS);
      end
      if (!out_ready) check(!in_ready, "R7", "in_ready during stall", in_ready, 0);
    end
    if (prev_stall)
      check(out_valid && {out_x, out_y, out_z} == prev_out, "R7", "hold",
            {out_x, out_y, out_z}, prev_out);
    out_ready = ordy;
    if (out_valid && !ordy) last_stall = cyc;
    if (out_valid && ordy && exp_q.size() != 0) begin
      void'(exp_q.pop_front());
      void'(acc_q.pop_front());
      void'(req_q.pop_front());
    end
    prev_stall = out_valid && !ordy;
    prev_out   = {out_x, out_y, out_z};
    in_valid = iv;
    in_a = DW'(a); in_b = DW'(b); in_c = DW'(c);
    coef_we = we;
    coef_a = CW'(ka); coef_b = CW'(kb); coef_c = CW'(kc);
    // R3 R8: model row update on the same edge as the beat
    if (we != 2'b00) begin
      mb[int'(we) - 1][0] = CW'(ka);
      mb[int'(we) - 1][1] = CW'(kb);
      mb[int'(we) - 1][2] = CW'(kc);
    end
    #1;
    if (iv && in_ready) begin
      exp_q.push_back({ref_dot(0, in_a, in_b, in_c), ref_dot(1, in_a, in_b, in_c),
                       ref_dot(2, in_a, in_b, in_c)});
      acc_q.push_back(cyc);
      req_q.push_back(cur_req);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 2'b00, 0, 0, 0, 1);
  endtask

  function automatic int rs(int lo, int hi);
    return lo + int'($urandom_range(hi - lo));
  endfunction

  initial begin
    for (int r = 0; r < 3; r++) for (int k = 0; k < 3; k++) mb[r][k] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    check({out_x, out_y, out_z} == '0, "R1", "outputs in reset", {out_x, out_y, out_z}, 0);
    rst_n = 1'b1;

    // R1: zero coefficients give zero results
    cur_req = "R1 R4";
    for (int i = 0; i < 8; i++) step(1, 300 * i - 1000, 2047 - i, -5 * i, 2'b00, 0, 0, 0, 1);
    idle(8);

    // R2 R4 R5: corner sweep of coefficients and data
    cur_req = "R2 R4 R5";
    for (int i = 0; i < 7; i++) begin
      step(0, 0, 0, 0, 2'b01, cvals[i], cvals[(i+1)%7], cvals[(i+2)%7], 1);
      step(0, 0, 0, 0, 2'b10, cvals[(i+3)%7], cvals[(i+4)%7], cvals[(i+5)%7], 1);
      step(0, 0, 0, 0, 2'b11, cvals[(i+6)%7], cvals[i], cvals[(i+3)%7], 1);
      for (int a = 0; a < 7; a++)
        for (int b = 0; b < 7; b++)
          for (int c = 0; c < 7; c++)
            step(1, dvals[a], dvals[b], dvals[c], 2'b00, 0, 0, 0, 1);
    end
    // R5: full-scale wrap and negative floor
    step(0, 0, 0, 0, 2'b01, 511, 511, 511, 1);
    step(0, 0, 0, 0, 2'b10, 1, 0, 0, 1);
    step(1, 2047, 2047, 2047, 2'b00, 0, 0, 0, 1);
    step(1, -1, 0, 0, 2'b00, 0, 0, 0, 1);
    step(1, -2048, -2048, -2048, 2'b00, 0, 0, 0, 1);
    idle(8);

    // R3: code 00 leaves every row alone, single-row writes touch one row
    cur_req = "R3 R4";
    for (int i = 0; i < 40; i++)
      step(1, rs(-2048, 2047), rs(-2048, 2047), rs(-2048, 2047), 2'b00,
           rs(-512, 511), rs(-512, 511), rs(-512, 511), 1);
    for (int w = 1; w < 4; w++) begin
      step(0, 0, 0, 0, 2'(w), rs(-512, 511), rs(-512, 511), rs(-512, 511), 1);
      for (int i = 0; i < 10; i++)
        step(1, rs(-2048, 2047), rs(-2048, 2047), rs(-2048, 2047), 2'b00, 0, 0, 0, 1);
    end
    idle(8);

    // R8: row writes on the same edge as beats
    cur_req = "R8 R4";
    for (int i = 0; i < 300; i++)
      step(1, rs(-2048, 2047), rs(-2048, 2047), rs(-2048, 2047), 2'(rs(0, 3)),
           rs(-512, 511), rs(-512, 511), rs(-512, 511), 1);
    idle(8);

    // R7: back-pressure, no coefficient writes
    cur_req = "R7 R4";
    for (int i = 0; i < 400; i++)
      step(rs(0, 3) != 0, rs(-2048, 2047), rs(-2048, 2047), rs(-2048, 2047), 2'b00,
           0, 0, 0, rs(0, 1) != 0);
    idle(12);

    // R9: bubbles in the input stream
    cur_req = "R9 R4";
    for (int i = 0; i < 300; i++)
      step(rs(0, 1) != 0, rs(-2048, 2047), rs(-2048, 2047), rs(-2048, 2047), 2'b00,
           0, 0, 0, 1);
    idle(10);
    check(out_valid == 1'b0, "R9", "valid after drain", out_valid, 0);
    check(exp_q.size() == 0, "R9", "results missing", exp_q.size(), 0);

    // R6: single beat on an empty pipeline
    cur_req = "R6 R4";
    step(1, 123, -456, 789, 2'b00, 0, 0, 0, 1);
    idle(8);
    check(exp_q.size() == 0, "R6", "single beat delivered", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R6 watchdog expired: actual %0d expected %0d", 200000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule